// File: doc/BRIEF.md
# Always-On Power Sequencer

This block is the state machine that lives in the always-on slow clock domain and steps the chip's main supply, the isolation clamps and the analog clock sources down when the fast domain asks for low power, and back up when a wakeup arrives. It talks to the fast domain through two level handshakes. Going down, the fast domain raises a low-power request, the sequencer answers with a power-down acknowledge, and the request is then withdrawn. Coming up, the sequencer raises a power-up request and holds it until the fast domain acknowledges. The configuration inputs come from a control register that has already been brought into the slow domain.

After reset the sequencer powers the chip up on its own. It turns main power on and waits for power-good. It enables the clocks and waits for their valid flags. It releases the environment clamp and then the main clamp. Only then does it ask the fast domain to start. On the way down the order is reversed: environment clamp on, main clamp on (the clock enables take their low-power values at the same moment), main power off as configured, and then the low-power state, where the wakeup lines are watched.

Top module: `pwr_slow_seq`

## Requirements
- R1: While reset is held, all three clock enables are 0, both clamps are 1, `main_pd_n_o` is 1, and `pwrup_req_o` and `pd_ack_o` are 0.
- R2: `slow_en_o` is always 1, and `slow_val_i` has no effect on any output.
- R3: On power-up, `main_pd_n_o` is 1, and the clock enables stay 0 until `main_pok_i` has been seen high. The enables are then set together: core = 1, io = 1, usb = `cfg_usb_act_i`. All of this happens before `pwrup_req_o` rises.
- R4: `pwrup_req_o` does not rise until every clock whose enable is 1 reports its valid input high. While this is pending, both clamps stay applied.
- R5: The environment clamp (`clamp_env_o`) always changes at least one cycle before the main clamp (`clamp_o`) makes the same change, in both directions.
- R6: Whenever `main_pd_n_o` is 0, both clamps are 1. The clamps are released only after `main_pd_n_o` is back at 1.
- R7: In the cycle the main clamp turns on during power-down, the enables become core = `cfg_core_lp_i`, io = `cfg_io_lp_i`, usb = `cfg_usb_lp_i` (1 = clock stays on in low power).
- R8: After the clamp step of a power-down, `main_pd_n_o` takes the value of `cfg_main_pd_n_i` (0 = remove main power). The low-power state is reached only once `main_pok_i` equals that value.
- R9: `wake_req_i` is sampled only in the low-power state. A wakeup asserted while the chip is active changes no output. Any set wakeup bit in low power starts a power-up.
- R10: `pwrup_req_o` stays 1 until `pwrup_ack_i` is seen high, and then falls. `pd_ack_o` rises after `lp_req_i` is seen high in the idle state, and stays 1 until `lp_req_i` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_slow_i | input | 1 | Always-on slow clock |
| rst_slow_ni | input | 1 | Active-low asynchronous reset |
| lp_req_i | input | 1 | Low-power request level from the fast domain |
| pwrup_ack_i | input | 1 | Fast-domain acknowledge of the power-up request |
| wake_req_i | input | NumWake | Wakeup request lines |
| main_pok_i | input | 1 | Main supply power-good |
| slow_val_i | input | 1 | Slow oscillator valid (ignored) |
| core_val_i | input | 1 | Core clock valid |
| io_val_i | input | 1 | IO clock valid |
| usb_val_i | input | 1 | USB clock valid |
| cfg_core_lp_i | input | 1 | Keep core clock on in low power |
| cfg_io_lp_i | input | 1 | Keep io clock on in low power |
| cfg_usb_lp_i | input | 1 | Keep usb clock on in low power |
| cfg_usb_act_i | input | 1 | Enable usb clock when active |
| cfg_main_pd_n_i | input | 1 | Main power level in low power (0 = off) |
| slow_en_o | output | 1 | Slow oscillator enable, tied on |
| core_en_o | output | 1 | Core clock enable |
| io_en_o | output | 1 | IO clock enable |
| usb_en_o | output | 1 | USB clock enable |
| main_pd_n_o | output | 1 | Active-low main power-down control |
| clamp_env_o | output | 1 | Environment isolation clamp |
| clamp_o | output | 1 | Main isolation clamp |
| pwrup_req_o | output | 1 | Power-up request level to the fast domain |
| pd_ack_o | output | 1 | Power-down acknowledge level to the fast domain |

## Verification
The bench holds power-good and the clock valid flags low on purpose. A sequencer that skips the power-good wait or the valid wait would show enables or a power-up request too early. Every clamp edge is checked against the environment clamp one sample earlier, and every edge of the power-down control is checked against the main clamp. An ordering slip in either direction, such as releasing both clamps in one step, therefore shows up immediately. Wakeups are pulsed while the chip is active to catch a design that latches them outside low power. Two opposite power-down configurations are run to catch enables or power-down levels that ignore the control bits.

// File: rtl/pwr_slow_pkg.sv
package pwr_slow_pkg;

  localparam int unsigned NumClk  = 3;
  localparam int unsigned ClkCore = 0;
  localparam int unsigned ClkIo   = 1;
  localparam int unsigned ClkUsb  = 2;

  typedef enum logic [3:0] {
    SqReset,
    SqLowPower,
    SqMainOn,
    SqClkOn,
    SqEnvRelease,
    SqClampRelease,
    SqReqUp,
    SqIdle,
    SqAckDown,
    SqEnvClamp,
    SqClampOn,
    SqMainOff
  } seq_state_e;

  // Enable pattern applied when the chip comes up.
  function automatic logic [NumClk-1:0] active_enables(input logic usb_act);
    logic [NumClk-1:0] r;
    r         = '1;
    r[ClkUsb] = usb_act;
    return r;
  endfunction

  // Every enabled clock reports valid.
  function automatic logic clocks_running(input logic [NumClk-1:0] en,
                                          input logic [NumClk-1:0] val);
    return &(val | ~en);
  endfunction

  // Every disabled clock has dropped its valid.
  function automatic logic clocks_stopped(input logic [NumClk-1:0] en,
                                          input logic [NumClk-1:0] val);
    return &(en | ~val);
  endfunction

endpackage

// File: rtl/pwr_slow_clk.sv
module pwr_slow_clk
  import pwr_slow_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ev_clk_on_i,
  input  logic              ev_clamp_on_i,
  input  logic              usb_act_i,
  input  logic [NumClk-1:0] cfg_lp_i,
  input  logic [NumClk-1:0] val_i,
  output logic [NumClk-1:0] en_o,
  output logic              up_ok_o,
  output logic              down_ok_o
);

  logic [NumClk-1:0] up_pattern;
  assign up_pattern = active_enables(usb_act_i);

  for (genvar g = 0; g < NumClk; g++) begin : g_en
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        en_o[g] <= 1'b0;
      end else if (ev_clk_on_i) begin
        en_o[g] <= up_pattern[g];
      end else if (ev_clamp_on_i) begin
        en_o[g] <= cfg_lp_i[g];
      end
    end
  end

  assign up_ok_o   = clocks_running(en_o, val_i);
  assign down_ok_o = clocks_stopped(en_o, val_i);

endmodule

// File: rtl/pwr_slow_rail.sv
module pwr_slow_rail (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ev_main_on_i,
  input  logic ev_env_rel_i,
  input  logic ev_clamp_rel_i,
  input  logic ev_env_clamp_i,
  input  logic ev_clamp_on_i,
  input  logic ev_main_off_i,
  input  logic cfg_pd_n_i,
  output logic env_clamp_o,
  output logic main_clamp_o,
  output logic pd_n_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      env_clamp_o  <= 1'b1;
      main_clamp_o <= 1'b1;
      pd_n_o       <= 1'b1;
    end else begin
      if (ev_env_rel_i)        env_clamp_o  <= 1'b0;
      else if (ev_env_clamp_i) env_clamp_o  <= 1'b1;
      if (ev_clamp_rel_i)      main_clamp_o <= 1'b0;
      else if (ev_clamp_on_i)  main_clamp_o <= 1'b1;
      if (ev_main_on_i)        pd_n_o       <= 1'b1;
      else if (ev_main_off_i)  pd_n_o       <= cfg_pd_n_i;
    end
  end

endmodule

// File: rtl/pwr_slow_fsm.sv
module pwr_slow_fsm
  import pwr_slow_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       lp_req_i,
  input  logic       pwrup_ack_i,
  input  logic       wake_any_i,
  input  logic       main_pok_i,
  input  logic       pd_n_q_i,
  input  logic       clk_up_ok_i,
  input  logic       clk_down_ok_i,
  output seq_state_e state_q_o,
  output seq_state_e state_d_o
);

  seq_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      SqReset:        state_d = SqMainOn;
      SqLowPower:     if (wake_any_i) state_d = SqMainOn;
      SqMainOn:       if (main_pok_i) state_d = SqClkOn;
      SqClkOn:        if (clk_up_ok_i) state_d = SqEnvRelease;
      SqEnvRelease:   state_d = SqClampRelease;
      SqClampRelease: state_d = SqReqUp;
      SqReqUp:        if (pwrup_ack_i) state_d = SqIdle;
      SqIdle:         if (lp_req_i) state_d = SqAckDown;
      SqAckDown:      if (!lp_req_i) state_d = SqEnvClamp;
      SqEnvClamp:     state_d = SqClampOn;
      SqClampOn:      if (clk_down_ok_i) state_d = SqMainOff;
      SqMainOff:      if (main_pok_i == pd_n_q_i) state_d = SqLowPower;
      default:        state_d = SqReset;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= SqReset;
    else         state_q <= state_d;
  end

  assign state_q_o = state_q;
  assign state_d_o = state_d;

endmodule

// File: rtl/pwr_slow_seq.sv
module pwr_slow_seq
  import pwr_slow_pkg::*;
#(
  parameter int unsigned NumWake = 6
) (
  input  logic               clk_slow_i,
  input  logic               rst_slow_ni,
  input  logic               lp_req_i,
  input  logic               pwrup_ack_i,
  input  logic [NumWake-1:0] wake_req_i,
  input  logic               main_pok_i,
  input  logic               slow_val_i,
  input  logic               core_val_i,
  input  logic               io_val_i,
  input  logic               usb_val_i,
  input  logic               cfg_core_lp_i,
  input  logic               cfg_io_lp_i,
  input  logic               cfg_usb_lp_i,
  input  logic               cfg_usb_act_i,
  input  logic               cfg_main_pd_n_i,
  output logic               slow_en_o,
  output logic               core_en_o,
  output logic               io_en_o,
  output logic               usb_en_o,
  output logic               main_pd_n_o,
  output logic               clamp_env_o,
  output logic               clamp_o,
  output logic               pwrup_req_o,
  output logic               pd_ack_o
);

  seq_state_e        state_q, state_d;
  logic [NumClk-1:0] clk_en, clk_val, clk_cfg_lp;
  logic              clk_up_ok, clk_down_ok, wake_any, pd_n_q;
  logic              slow_val_unused;

  // Named entry events: one cycle high on the edge that enters a state.
  logic ev_main_on, ev_clk_on, ev_env_rel, ev_clamp_rel;
  logic ev_env_clamp, ev_clamp_on, ev_main_off;

  assign slow_val_unused = slow_val_i;
  assign wake_any        = |wake_req_i;

  assign ev_main_on   = (state_d == SqMainOn)       && (state_q != SqMainOn);
  assign ev_clk_on    = (state_d == SqClkOn)        && (state_q != SqClkOn);
  assign ev_env_rel   = (state_d == SqEnvRelease)   && (state_q != SqEnvRelease);
  assign ev_clamp_rel = (state_d == SqClampRelease) && (state_q != SqClampRelease);
  assign ev_env_clamp = (state_d == SqEnvClamp)     && (state_q != SqEnvClamp);
  assign ev_clamp_on  = (state_d == SqClampOn)      && (state_q != SqClampOn);
  assign ev_main_off  = (state_d == SqMainOff)      && (state_q != SqMainOff);

  assign clk_val[ClkCore]    = core_val_i;
  assign clk_val[ClkIo]      = io_val_i;
  assign clk_val[ClkUsb]     = usb_val_i;
  assign clk_cfg_lp[ClkCore] = cfg_core_lp_i;
  assign clk_cfg_lp[ClkIo]   = cfg_io_lp_i;
  assign clk_cfg_lp[ClkUsb]  = cfg_usb_lp_i;

  pwr_slow_fsm u_fsm (
    .clk_i         (clk_slow_i),
    .rst_ni        (rst_slow_ni),
    .lp_req_i      (lp_req_i),
    .pwrup_ack_i   (pwrup_ack_i),
    .wake_any_i    (wake_any),
    .main_pok_i    (main_pok_i),
    .pd_n_q_i      (pd_n_q),
    .clk_up_ok_i   (clk_up_ok),
    .clk_down_ok_i (clk_down_ok),
    .state_q_o     (state_q),
    .state_d_o     (state_d)
  );

  pwr_slow_clk u_clk (
    .clk_i         (clk_slow_i),
    .rst_ni        (rst_slow_ni),
    .ev_clk_on_i   (ev_clk_on),
    .ev_clamp_on_i (ev_clamp_on),
    .usb_act_i     (cfg_usb_act_i),
    .cfg_lp_i      (clk_cfg_lp),
    .val_i         (clk_val),
    .en_o          (clk_en),
    .up_ok_o       (clk_up_ok),
    .down_ok_o     (clk_down_ok)
  );

  pwr_slow_rail u_rail (
    .clk_i          (clk_slow_i),
    .rst_ni         (rst_slow_ni),
    .ev_main_on_i   (ev_main_on),
    .ev_env_rel_i   (ev_env_rel),
    .ev_clamp_rel_i (ev_clamp_rel),
    .ev_env_clamp_i (ev_env_clamp),
    .ev_clamp_on_i  (ev_clamp_on),
    .ev_main_off_i  (ev_main_off),
    .cfg_pd_n_i     (cfg_main_pd_n_i),
    .env_clamp_o    (clamp_env_o),
    .main_clamp_o   (clamp_o),
    .pd_n_o         (pd_n_q)
  );

  assign slow_en_o   = 1'b1;
  assign core_en_o   = clk_en[ClkCore];
  assign io_en_o     = clk_en[ClkIo];
  assign usb_en_o    = clk_en[ClkUsb];
  assign main_pd_n_o = pd_n_q;
  assign pwrup_req_o = (state_q == SqReqUp);
  assign pd_ack_o    = (state_q == SqAckDown);

endmodule

// File: rtl/pwr_slow_seq_chk.sv
module pwr_slow_seq_chk (
  input logic clk_slow_i,
  input logic rst_slow_ni,
  input logic lp_req_i,
  input logic pwrup_ack_i,
  input logic main_pok_i,
  input logic core_val_i,
  input logic io_val_i,
  input logic usb_val_i,
  input logic slow_en_o,
  input logic core_en_o,
  input logic io_en_o,
  input logic usb_en_o,
  input logic main_pd_n_o,
  input logic clamp_env_o,
  input logic clamp_o,
  input logic pwrup_req_o,
  input logic pd_ack_o
);

  assert_slow_on_R2: assert property (@(posedge clk_slow_i)
    disable iff (!rst_slow_ni) slow_en_o);

  assert_pok_before_clk_R3: assert property (@(posedge clk_slow_i)
    disable iff (!rst_slow_ni) $rose(core_en_o) |-> $past(main_pok_i) && main_pd_n_o);

  assert_req_after_clk_R3: assert property (@(posedge clk_slow_i)
    disable iff (!rst_slow_ni) $rose(pwrup_req_o) |-> core_en_o && io_en_o && main_pd_n_o);

  assert_clk_valid_R4: assert property (@(posedge clk_slow_i)
    disable iff (!rst_slow_ni) $rose(pwrup_req_o) |->
      $past((!core_en_o || core_val_i) && (!io_en_o || io_val_i) && (!usb_en_o || usb_val_i)));

  assert_env_first_off_R5: assert property (@(posedge clk_slow_i)
    disable iff (!rst_slow_ni) $fell(clamp_o) |-> $past(!clamp_env_o));

  assert_env_first_on_R5: assert property (@(posedge clk_slow_i)
    disable iff (!rst_slow_ni) $rose(clamp_o) |-> $past(clamp_env_o));

  assert_clamp_covers_pd_R6: assert property (@(posedge clk_slow_i)
    disable iff (!rst_slow_ni) !main_pd_n_o |-> clamp_o && clamp_env_o);

  assert_req_hold_R10: assert property (@(posedge clk_slow_i)
    disable iff (!rst_slow_ni) pwrup_req_o && !pwrup_ack_i |=> pwrup_req_o);

  assert_ack_hold_R10: assert property (@(posedge clk_slow_i)
    disable iff (!rst_slow_ni) pd_ack_o && lp_req_i |=> pd_ack_o);

endmodule

bind pwr_slow_seq pwr_slow_seq_chk u_chk (
  .clk_slow_i  (clk_slow_i),
  .rst_slow_ni (rst_slow_ni),
  .lp_req_i    (lp_req_i),
  .pwrup_ack_i (pwrup_ack_i),
  .main_pok_i  (main_pok_i),
  .core_val_i  (core_val_i),
  .io_val_i    (io_val_i),
  .usb_val_i   (usb_val_i),
  .slow_en_o   (slow_en_o),
  .core_en_o   (core_en_o),
  .io_en_o     (io_en_o),
  .usb_en_o    (usb_en_o),
  .main_pd_n_o (main_pd_n_o),
  .clamp_env_o (clamp_env_o),
  .clamp_o     (clamp_o),
  .pwrup_req_o (pwrup_req_o),
  .pd_ack_o    (pd_ack_o)
);

// File: tb/pwr_slow_seq_test.sv
`timescale 1ns/1ps
module pwr_slow_seq_test;

  localparam int NW = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lp_req = 1'b0, pwrup_ack = 1'b0, slow_val = 1'b0;
  logic [NW-1:0] wake = '0;
  logic cfg_core_lp = 1'b0, cfg_io_lp = 1'b0, cfg_usb_lp = 1'b0;
  logic cfg_usb_act = 1'b0, cfg_pd_n = 1'b0;
  logic block_pok = 1'b1, hold_val = 1'b0;
  logic main_pok, core_val, io_val, usb_val;
  logic slow_en, core_en, io_en, usb_en, main_pd_n, clamp_env, clamp, pwrup_req, pd_ack;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  // Analog model: valids and power-good follow their controls three cycles late.
  logic [2:0] d_core = '0, d_io = '0, d_usb = '0, d_pok = '0;
  always @(negedge clk) begin
    d_core <= {d_core[1:0], core_en};
    d_io   <= {d_io[1:0],   io_en};
    d_usb  <= {d_usb[1:0],  usb_en};
    d_pok  <= {d_pok[1:0],  main_pd_n};
  end
  assign core_val = d_core[2] & ~hold_val;
  assign io_val   = d_io[2]   & ~hold_val;
  assign usb_val  = d_usb[2]  & ~hold_val;
  assign main_pok = d_pok[2]  & ~block_pok;

  pwr_slow_seq #(.NumWake(NW)) uut (
    .clk_slow_i(clk), .rst_slow_ni(rst_n), .lp_req_i(lp_req), .pwrup_ack_i(pwrup_ack),
    .wake_req_i(wake), .main_pok_i(main_pok), .slow_val_i(slow_val),
    .core_val_i(core_val), .io_val_i(io_val), .usb_val_i(usb_val),
    .cfg_core_lp_i(cfg_core_lp), .cfg_io_lp_i(cfg_io_lp), .cfg_usb_lp_i(cfg_usb_lp),
    .cfg_usb_act_i(cfg_usb_act), .cfg_main_pd_n_i(cfg_pd_n),
    .slow_en_o(slow_en), .core_en_o(core_en), .io_en_o(io_en), .usb_en_o(usb_en),
    .main_pd_n_o(main_pd_n), .clamp_env_o(clamp_env), .clamp_o(clamp),
    .pwrup_req_o(pwrup_req), .pd_ack_o(pd_ack)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Ordering monitor: clamp edges against the environment clamp, power-down edges against the clamp.
  logic prev_env = 1'b1, prev_clamp = 1'b1, prev_pdn = 1'b1;
  always @(negedge clk) begin
    if (rst_n) begin
      if (clamp !== prev_clamp) check(prev_env === clamp, "R5 env clamp leads main clamp", prev_env, clamp);
      if (main_pd_n !== prev_pdn) check(clamp === 1'b1, "R6 clamp held across pd edge", clamp, 1);
    end
    prev_env   <= clamp_env;
    prev_clamp <= clamp;
    prev_pdn   <= main_pd_n;
  end

  task automatic finish_ack();
    while (pwrup_req !== 1'b1) @(negedge clk);
    pwrup_ack = 1'b1;
    cycles(1);
    check(pwrup_req === 1'b0, "R10 req drops after ack", pwrup_req, 0);
    pwrup_ack = 1'b0;
    cycles(2);
  endtask

  task automatic power_down();
    lp_req = 1'b1;
    while (pd_ack !== 1'b1) @(negedge clk);
    cycles(6);
    check(pd_ack === 1'b1, "R10 pd_ack held while lp_req", pd_ack, 1);
    lp_req = 1'b0;
    while (clamp !== 1'b1) @(negedge clk);
    check(clamp_env === 1'b1, "R5 env clamp on with main clamp", clamp_env, 1);
  endtask

  task automatic t_reset();
    cycles(2);
    check({core_en, io_en, usb_en} === 3'b000, "R1 enables low in reset", {core_en, io_en, usb_en}, 0);
    check({clamp_env, clamp, main_pd_n} === 3'b111, "R1 clamps and pd_n in reset", {clamp_env, clamp, main_pd_n}, 7);
    check({pwrup_req, pd_ack} === 2'b00, "R1 handshakes low in reset", {pwrup_req, pd_ack}, 0);
    check(slow_en === 1'b1, "R2 slow enable in reset", slow_en, 1);
  endtask

  task automatic t_first_powerup();
    rst_n = 1'b1;
    cycles(10);
    check(core_en === 1'b0, "R3 no clocks before power-good", core_en, 0);
    check(main_pd_n === 1'b1, "R3 main powered on", main_pd_n, 1);
    hold_val  = 1'b1;
    block_pok = 1'b0;
    while (core_en !== 1'b1) @(negedge clk);
    check(io_en === 1'b1, "R3 io enabled on power-up", io_en, 1);
    check(usb_en === 1'b0, "R3 usb follows active bit 0", usb_en, 0);
    check(main_pok === 1'b1, "R3 power-good seen", main_pok, 1);
    cycles(10);
    check(pwrup_req === 1'b0, "R4 no request without valids", pwrup_req, 0);
    check(clamp === 1'b1, "R4 clamp held without valids", clamp, 1);
    hold_val = 1'b0;
    while (pwrup_req !== 1'b1) @(negedge clk);
    check({clamp_env, clamp} === 2'b00, "R6 clamps released at request", {clamp_env, clamp}, 0);
    cycles(8);
    check(pwrup_req === 1'b1, "R10 request held without ack", pwrup_req, 1);
    finish_ack();
  endtask

  task automatic t_wake_active();
    wake = 6'b010010;
    slow_val = 1'b1;
    cycles(3);
    wake = '0;
    slow_val = 1'b0;
    cycles(10);
    check({pwrup_req, pd_ack, clamp, main_pd_n, core_en} === 5'b00011,
          "R9 wake ignored while active", {pwrup_req, pd_ack, clamp, main_pd_n, core_en}, 3);
    check(slow_en === 1'b1, "R2 slow enable ignores valid", slow_en, 1);
  endtask

  task automatic t_down_off();
    cfg_core_lp = 1'b0; cfg_io_lp = 1'b1; cfg_usb_lp = 1'b0; cfg_pd_n = 1'b0;
    power_down();
    check({core_en, io_en, usb_en} === 3'b010, "R7 enables take low-power bits",
          {core_en, io_en, usb_en}, 3'b010);
    for (int i = 0; i < 20 && main_pd_n !== 1'b0; i++) @(negedge clk);
    check(main_pd_n === 1'b0, "R8 main power removed", main_pd_n, 0);
    cycles(20);
    check({pwrup_req, main_pd_n, clamp} === 3'b001, "R8 resting in low power", {pwrup_req, main_pd_n, clamp}, 1);
    cfg_usb_act = 1'b1;
    wake = 6'b000100;
    cycles(2);
    wake = '0;
    while (pwrup_req !== 1'b1) @(negedge clk);
    check(usb_en === 1'b1, "R3 usb follows active bit 1", usb_en, 1);
    check(main_pd_n === 1'b1, "R9 wake restored power", main_pd_n, 1);
    finish_ack();
  endtask

  task automatic t_down_on();
    cfg_core_lp = 1'b1; cfg_io_lp = 1'b1; cfg_usb_lp = 1'b1; cfg_pd_n = 1'b1;
    power_down();
    check({core_en, io_en, usb_en} === 3'b111, "R7 clocks kept in low power",
          {core_en, io_en, usb_en}, 3'b111);
    cycles(20);
    check(main_pd_n === 1'b1, "R8 main power kept", main_pd_n, 1);
    check(clamp === 1'b1, "R6 clamp held in low power", clamp, 1);
    wake = 6'b100000;
    cycles(1);
    wake = '0;
    while (pwrup_req !== 1'b1) @(negedge clk);
    check(clamp === 1'b0, "R9 wake brought chip up", clamp, 0);
    finish_ack();
  endtask

  initial begin
    t_reset();
    t_first_powerup();
    t_wake_active();
    t_down_off();
    t_down_on();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule